// File: doc/BRIEF.md
# Edge-Detecting Interrupt and Quasi-Interrupt Unit

This unit watches five asynchronous pins: one external interrupt pin and a group of four key-scan pins. Each pin goes through a two-flop synchroniser and then a stability filter. The filter accepts a new level only after that level has held for a programmable number of clocks. Pulses shorter than that window never reach the edge logic.

Edges on the filtered external pin set a pending flag that feeds the vectored interrupt request. The edge direction is chosen by a select input. A falling edge on any filtered key pin sets one shared quasi-interrupt flag, which carries no vector. Each flag has an enable that gates its setting, and a clear pulse that resets it. A wake output is high while any pending flag has its enable high.

All pins here are control and status pins, so the unit has no valid/ready stream interface and no back-pressure.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset, `ext_pend`, `key_pend` and `wake` are 0.
- R2: Every pin passes through two synchroniser flops. A new pin level is accepted only after it has held for `filt_len` consecutive clocks, where a `filt_len` of 0 acts as 1. A pulse shorter than this is dropped and sets no flag.
- R3: A pin change made between clock edges sets its flag on the (N+3)th rising edge after the change, where N is the effective filter length. The flag is still 0 after the (N+2)th edge.
- R4: With `ext_rise_sel`=1 only rising edges of the filtered external pin are detected. With `ext_rise_sel`=0 only falling edges are detected. An edge in the other direction leaves `ext_pend` unchanged.
- R5: A falling edge on any of the four key pins sets `key_pend`. Rising key edges have no effect.
- R6: A detected edge sets its flag only if that flag's enable is 1 in the detection cycle. An edge detected while the enable is 0 is lost, and later enabling does not recover it.
- R7: A pending flag stays at 1 until a clear pulse. A 1 on `ext_clr` or `key_clr` resets that flag at the next clock edge.
- R8: If a detection and a clear fall in the same cycle, the flag ends at 1.
- R9: `wake` is 1 exactly when (`ext_pend` and `ext_en`) or (`key_pend` and `key_en`).
- R10: The filtered state of every pin resets to 1, so pins already high when reset is released produce no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_len | input | FW (4) | Filter length in clocks (0 acts as 1) |
| ext_rise_sel | input | 1 | 1 = rising edge, 0 = falling edge on the external pin |
| ext_en | input | 1 | Enable for the external pending flag |
| key_en | input | 1 | Enable for the key quasi-interrupt flag |
| ext_clr | input | 1 | Clear pulse for `ext_pend` |
| key_clr | input | 1 | Clear pulse for `key_pend` |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| key_pin | input | NKEY (4) | Key-scan pins, asynchronous, idle high |
| ext_pend | output | 1 | External vectored request pending |
| key_pend | output | 1 | Quasi-interrupt flag |
| wake | output | 1 | Any enabled flag pending |

## Verification
The assertions assume that `filt_len` is held constant while a pin is moving. They also assume that reset starts with the pins high. The bench changes `filt_len` only after every pin has been idle for longer than the filter window. It drives all pins and controls at falling clock edges, so each pin change has a known position between rising edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_t;
  localparam int NKEY_DEF = 4;
  localparam int FW_DEF   = 4;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] filt_len,
  input  logic          pin,
  output logic          level,
  output logic          rise_p,
  output logic          fall_p
);
  logic          s;
  logic [FW-1:0] cnt;
  logic [FW-1:0] eff;

  sync2 #(.RST_VAL(1'b1)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin), .q(s));

  assign eff = (filt_len == '0) ? {{(FW-1){1'b0}}, 1'b1} : filt_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= 1'b1;
      cnt    <= '0;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (s == level) begin
        cnt <= '0;
      end else if (cnt == eff - 1'b1) begin
        level  <= s;
        cnt    <= '0;
        rise_p <= s;
        fall_p <= ~s;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: an accepted level is the synchronised value seen one cycle earlier
  p_level_from_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(s) == level));
  // R2: the run counter never reaches the window length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < eff);
  // R2: the edge pulses mirror the level change
  p_pulse_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p || fall_p) |-> (level != $past(level)));
endmodule

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  // R8: a detection wins over a clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R7: the flag holds without a clear
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
  // R7: a clear without a detection drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import irq_pkg::*;
#(
  parameter int NKEY = NKEY_DEF,
  parameter int FW   = FW_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FW-1:0]   filt_len,
  input  logic            ext_rise_sel,
  input  logic            ext_en,
  input  logic            key_en,
  input  logic            ext_clr,
  input  logic            key_clr,
  input  logic            ext_pin,
  input  logic [NKEY-1:0] key_pin,
  output logic            ext_pend,
  output logic            key_pend,
  output logic            wake
);
  localparam int NPIN = NKEY + 1;

  logic [NPIN-1:0] pins, lvl, rp, fp;
  logic            ext_hit, key_hit;
  edge_t           ext_mode;

  assign pins     = {key_pin, ext_pin};
  assign ext_mode = edge_t'(ext_rise_sel);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_filter #(.FW(FW)) u_filt (
      .clk(clk), .rst_n(rst_n), .filt_len(filt_len), .pin(pins[i]),
      .level(lvl[i]), .rise_p(rp[i]), .fall_p(fp[i])
    );
  end

  assign ext_hit = ext_en & ((ext_mode == EDGE_RISE) ? rp[0] : fp[0]);
  assign key_hit = key_en & (|fp[NPIN-1:1]);

  pend_flag u_ext (.clk(clk), .rst_n(rst_n), .set(ext_hit), .clr(ext_clr), .q(ext_pend));
  pend_flag u_key (.clk(clk), .rst_n(rst_n), .set(key_hit), .clr(key_clr), .q(key_pend));

  assign wake = (ext_pend & ext_en) | (key_pend & key_en);

  // R6: a new external request needs the enable in the detection cycle
  p_ext_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_pend) |-> $past(ext_en));
  // R6: same for the quasi-interrupt flag
  p_key_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pend) |-> $past(key_en));
  // R5: the key flag rises only after some key level fell
  p_key_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pend) |-> ($past(lvl[NPIN-1:1]) != {NKEY{1'b1}}));
  // R9: no wake without a pending flag
  p_wake_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_pend && !key_pend) |-> !wake);
endmodule

// File: tb/sim_edge_irq_unit.sv
module sim_edge_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] filt_len = 4'd1;
  logic       ext_rise_sel = 1'b0, ext_en = 1'b1, key_en = 1'b1;
  logic       ext_clr = 1'b0, key_clr = 1'b0;
  logic       ext_pin = 1'b1;
  logic [3:0] key_pin = 4'hF;
  logic       ext_pend, key_pend, wake;
  int         n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  edge_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .filt_len(filt_len), .ext_rise_sel(ext_rise_sel),
    .ext_en(ext_en), .key_en(key_en), .ext_clr(ext_clr), .key_clr(key_clr),
    .ext_pin(ext_pin), .key_pin(key_pin),
    .ext_pend(ext_pend), .key_pend(key_pend), .wake(wake)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic clear_all();
    ext_clr = 1'b1; key_clr = 1'b1; step(1);
    ext_clr = 1'b0; key_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);
    chk(ext_pend, 1'b0, "R1 ext_pend");
    chk(key_pend, 1'b0, "R1 key_pend");
    chk(wake, 1'b0, "R1 wake");
    rst_n = 1'b1;
    step(10);
    chk(ext_pend | key_pend, 1'b0, "R10 no edge after reset release");

    // R2 sweep: filter length versus low-pulse length on keys and ext falling
    for (int n = 0; n <= 4; n++) begin
      filt_len = 4'(n);
      step(2);
      for (int l = 1; l <= 6; l++) begin
        int ne;
        ne = (n == 0) ? 1 : n;
        key_pin[l % 4] = 1'b0; ext_pin = 1'b0;
        step(l);
        key_pin = 4'hF; ext_pin = 1'b1;
        step(ne + 8);
        chk(key_pend, (l >= ne), $sformatf("R2 key N=%0d L=%0d", n, l));
        chk(ext_pend, (l >= ne), $sformatf("R2 ext N=%0d L=%0d", n, l));
        clear_all();
        step(2);
      end
      // R3 latency
      ext_pin = 1'b0;
      step(ne_of(n) + 2);
      chk(ext_pend, 1'b0, $sformatf("R3 early N=%0d", n));
      step(1);
      chk(ext_pend, 1'b1, $sformatf("R3 on time N=%0d", n));
      ext_pin = 1'b1;
      step(10);
      clear_all();
    end

    // R4 rising select, high glitches on a low pin
    filt_len = 4'd3;
    ext_rise_sel = 1'b1;
    ext_pin = 1'b0; step(12);
    chk(ext_pend, 1'b0, "R4 falling ignored when rising selected");
    for (int l = 1; l <= 5; l++) begin
      ext_pin = 1'b1; step(l); ext_pin = 1'b0; step(12);
      chk(ext_pend, (l >= 3), $sformatf("R4 rise L=%0d", l));
      clear_all();
    end
    ext_pin = 1'b1; step(12); clear_all();
    ext_rise_sel = 1'b0;
    step(4);
    chk(ext_pend, 1'b0, "R4 cleared after rising test");

    // R5 key rising edges ignored
    key_pin[2] = 1'b0; step(12); clear_all(); step(2);
    key_pin[2] = 1'b1; step(12);
    chk(key_pend, 1'b0, "R5 key rising ignored");

    // R6 disabled edges are lost
    key_en = 1'b0; ext_en = 1'b0;
    key_pin[0] = 1'b0; ext_pin = 1'b0; step(12);
    chk(key_pend, 1'b0, "R6 key disabled");
    chk(ext_pend, 1'b0, "R6 ext disabled");
    key_en = 1'b1; ext_en = 1'b1; step(4);
    chk(key_pend | ext_pend, 1'b0, "R6 not recovered");
    key_pin = 4'hF; ext_pin = 1'b1; step(12);

    // R7 hold then clear, R9 wake gating
    ext_pin = 1'b0; step(12);
    chk(ext_pend, 1'b1, "R7 set");
    chk(wake, 1'b1, "R9 wake with ext");
    ext_en = 1'b0; step(1);
    chk(wake, 1'b0, "R9 wake gated by ext_en");
    chk(ext_pend, 1'b1, "R7 holds while disabled");
    ext_en = 1'b1; step(20);
    chk(ext_pend, 1'b1, "R7 still held");
    ext_clr = 1'b1; step(1); ext_clr = 1'b0;
    chk(ext_pend, 1'b0, "R7 cleared");
    ext_pin = 1'b1; step(12);

    // R8 clear and detection in the same cycle (filt_len=3)
    key_pin[1] = 1'b0; step(12); key_pin[1] = 1'b1; step(12);
    chk(key_pend, 1'b1, "R8 pre-set");
    chk(wake, 1'b1, "R9 wake with key");
    key_pin[3] = 1'b0;
    step(5);
    key_clr = 1'b1; step(1); key_clr = 1'b0;
    chk(key_pend, 1'b1, "R8 detection wins");
    step(1);
    key_clr = 1'b1; step(1); key_clr = 1'b0;
    chk(key_pend, 1'b0, "R7 key cleared");
    key_pin = 4'hF; step(12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int ne_of(input int n);
    return (n == 0) ? 1 : n;
  endfunction
endmodule